// File: doc/BRIEF.md
# Packet Load Sequencer

This block is the control state machine that steps one incoming packet into the output queue picked by the packet's address. It watches the input valid flag, the address bits of the first byte, the full flag of the selected queue, the empty flags of all output queues and two status flags from the datapath. The parity-complete flag reports that the last byte has been taken. The input-ended flag reports that the valid flag dropped while the sequencer was stalled. From these it drives one-hot phase flags, a write enable for the selected queue, a clear pulse for the datapath's input-ended flag, and a busy signal that tells the sender to hold its byte.

Storage of the bytes, the parity arithmetic and the routing of the write enable to a queue are all outside this block. The sequencer's only storage apart from its state is the captured destination index. It uses that index to wait until the addressed queue has drained before it starts loading.

Top module: `pkt_load_ctrl`

## Requirements
- R1: After reset the block is idle: hdr_detect_o=1 and every other output is 0.
- R2: In idle, if pkt_valid_i=1, addr_i<NUM_PORTS and fifo_empty_i[addr_i]=1, the next cycle shows first_load_o=1, busy_o=1. If pkt_valid_i=0 or addr_i=3 (invalid), it stays idle.
- R3: In idle, a valid packet whose queue is not empty leads to the wait phase (busy_o=1, all other outputs 0). The wait phase uses the index captured at acceptance, ignores addr_i and the other queues' flags, and moves to the first-load phase once that queue's empty flag is 1.
- R4: The first-load phase (first_load_o=1, busy_o=1) always lasts one cycle and is followed by the data phase, whatever the inputs are.
- R5: The data phase shows data_load_o=1, wr_en_o=1, busy_o=0. fifo_full_i=1 leads to the full-hold phase and takes priority over pkt_valid_i. Otherwise pkt_valid_i=0 leads to the parity phase. Otherwise the block stays in the data phase.
- R6: The parity phase (wr_en_o=1, busy_o=1, no phase flag) always leads to the check phase.
- R7: The check phase shows parity_clr_o=1, busy_o=1. fifo_full_i=1 leads to the full-hold phase, otherwise to idle.
- R8: The full-hold phase shows full_hold_o=1, busy_o=1, wr_en_o=0. It repeats while fifo_full_i=1 and goes to the after-full phase when fifo_full_i=0.
- R9: The after-full phase shows after_full_load_o=1, wr_en_o=1, busy_o=1. parity_seen_i=1 leads to idle (priority). Otherwise pkt_ended_i=1 leads to the parity phase. Otherwise the block goes to the data phase.
- R10: At most one of the six phase flags is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Input packet valid |
| addr_i | input | ADDR_W | Destination bits of the input byte |
| fifo_full_i | input | 1 | Full flag of the selected queue |
| fifo_empty_i | input | NUM_PORTS | Empty flags of all output queues |
| parity_seen_i | input | 1 | Datapath has taken the parity byte |
| pkt_ended_i | input | 1 | Valid dropped during a stall |
| hdr_detect_o | output | 1 | Idle, waiting for a header |
| first_load_o | output | 1 | Header load phase |
| data_load_o | output | 1 | Payload load phase |
| after_full_load_o | output | 1 | Load of the byte held during a stall |
| full_hold_o | output | 1 | Stalled on a full queue |
| wr_en_o | output | 1 | Write enable for the selected queue |
| parity_clr_o | output | 1 | Clears the input-ended flag |
| busy_o | output | 1 | Sender must hold its byte |

## Verification
Every output is a decode of the state register, so each response is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge and reads all outputs 1 ns after the next rising edge, one step per check. The idle decision is swept over every address and every empty-flag pattern. Each transition out of the other phases is then walked with the competing flags raised together, to expose the priorities.

// File: rtl/pkt_fsm_pkg.sv
package pkt_fsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FIRST  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_FULL   = 3'd4,
    ST_AFTER  = 3'd5,
    ST_WAIT   = 3'd6,
    ST_CHECK  = 3'd7
  } fsm_state_e;

  typedef struct packed {
    logic hdr_detect;
    logic first_load;
    logic data_load;
    logic after_full_load;
    logic full_hold;
    logic wr_en;
    logic parity_clr;
    logic busy;
  } fsm_out_t;
endpackage

// File: rtl/pkt_fsm_target.sv
module pkt_fsm_target #(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 capture_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_PORTS-1:0] fifo_empty_i,
  output logic                 addr_ok_o,
  output logic                 addr_empty_o,
  output logic                 tgt_empty_o
);
  logic [ADDR_W-1:0] tgt_q;

  assign addr_ok_o = (int'(addr_i) < NUM_PORTS);

  always_comb begin
    addr_empty_o = 1'b0;
    tgt_empty_o  = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(addr_i) == p) addr_empty_o = fifo_empty_i[p];
      if (int'(tgt_q)  == p) tgt_empty_o  = fifo_empty_i[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tgt_q <= '0;
    else if (capture_i) tgt_q <= addr_i;
  end
endmodule

// File: rtl/pkt_fsm_next.sv
module pkt_fsm_next
  import pkt_fsm_pkg::*;
(
  input  fsm_state_e state_i,
  input  logic       pkt_valid_i,
  input  logic       addr_ok_i,
  input  logic       addr_empty_i,
  input  logic       tgt_empty_i,
  input  logic       fifo_full_i,
  input  logic       parity_seen_i,
  input  logic       pkt_ended_i,
  output logic       capture_o,
  output fsm_state_e state_o
);
  always_comb begin
    state_o   = state_i;
    capture_o = 1'b0;
    unique case (state_i)
      ST_IDLE: if (pkt_valid_i && addr_ok_i) begin
        capture_o = 1'b1;
        state_o   = addr_empty_i ? ST_FIRST : ST_WAIT;
      end
      ST_WAIT:   if (tgt_empty_i) state_o = ST_FIRST;
      ST_FIRST:  state_o = ST_DATA;
      ST_DATA: begin
        if (fifo_full_i)       state_o = ST_FULL;
        else if (!pkt_valid_i) state_o = ST_PARITY;
      end
      ST_PARITY: state_o = ST_CHECK;
      ST_CHECK:  state_o = fifo_full_i ? ST_FULL : ST_IDLE;
      ST_FULL:   if (!fifo_full_i) state_o = ST_AFTER;
      ST_AFTER: begin
        if (parity_seen_i)    state_o = ST_IDLE;
        else if (pkt_ended_i) state_o = ST_PARITY;
        else                  state_o = ST_DATA;
      end
      default: state_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pkt_fsm_decode.sv
module pkt_fsm_decode
  import pkt_fsm_pkg::*;
(
  input  fsm_state_e state_i,
  output fsm_out_t   out_o
);
  always_comb begin
    out_o = '0;
    unique case (state_i)
      ST_IDLE:   out_o.hdr_detect = 1'b1;
      ST_FIRST:  begin out_o.first_load = 1'b1; out_o.busy = 1'b1; end
      ST_DATA:   begin out_o.data_load = 1'b1; out_o.wr_en = 1'b1; end
      ST_PARITY: begin out_o.wr_en = 1'b1; out_o.busy = 1'b1; end
      ST_CHECK:  begin out_o.parity_clr = 1'b1; out_o.busy = 1'b1; end
      ST_FULL:   begin out_o.full_hold = 1'b1; out_o.busy = 1'b1; end
      ST_AFTER:  begin
        out_o.after_full_load = 1'b1; out_o.wr_en = 1'b1; out_o.busy = 1'b1;
      end
      ST_WAIT:   out_o.busy = 1'b1;
      default:   out_o = '0;
    endcase
  end
endmodule

// File: rtl/pkt_load_ctrl.sv
module pkt_load_ctrl
  import pkt_fsm_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pkt_valid_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 fifo_full_i,
  input  logic [NUM_PORTS-1:0] fifo_empty_i,
  input  logic                 parity_seen_i,
  input  logic                 pkt_ended_i,
  output logic                 hdr_detect_o,
  output logic                 first_load_o,
  output logic                 data_load_o,
  output logic                 after_full_load_o,
  output logic                 full_hold_o,
  output logic                 wr_en_o,
  output logic                 parity_clr_o,
  output logic                 busy_o
);
  fsm_state_e state_q, state_d;
  fsm_out_t   dec;
  logic       capture, addr_ok, addr_empty, tgt_empty;

  pkt_fsm_target #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_target (
    .clk_i, .rst_ni,
    .capture_i    (capture),
    .addr_i,
    .fifo_empty_i,
    .addr_ok_o    (addr_ok),
    .addr_empty_o (addr_empty),
    .tgt_empty_o  (tgt_empty)
  );

  pkt_fsm_next u_next (
    .state_i       (state_q),
    .pkt_valid_i,
    .addr_ok_i     (addr_ok),
    .addr_empty_i  (addr_empty),
    .tgt_empty_i   (tgt_empty),
    .fifo_full_i,
    .parity_seen_i,
    .pkt_ended_i,
    .capture_o     (capture),
    .state_o       (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  pkt_fsm_decode u_decode (.state_i(state_q), .out_o(dec));

  assign hdr_detect_o      = dec.hdr_detect;
  assign first_load_o      = dec.first_load;
  assign data_load_o       = dec.data_load;
  assign after_full_load_o = dec.after_full_load;
  assign full_hold_o       = dec.full_hold;
  assign wr_en_o           = dec.wr_en;
  assign parity_clr_o      = dec.parity_clr;
  assign busy_o            = dec.busy;

  a_r4_first_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_load_o |=> data_load_o);
  a_r5_full_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_load_o && fifo_full_i) |=> full_hold_o);
  a_r5_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_load_o |-> !busy_o);
  a_r7_check_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_clr_o && !fifo_full_i) |=> hdr_detect_o);
  a_r8_no_write_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_hold_o |-> !wr_en_o);
  a_r9_parity_seen_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (after_full_load_o && parity_seen_i) |=> hdr_detect_o);
  a_r10_onehot_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hdr_detect_o, first_load_o, data_load_o, after_full_load_o,
              full_hold_o, parity_clr_o}));
endmodule

// File: tb/pkt_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module pkt_load_ctrl_tb_top;
  // expected vector: {hdr, first, data, after, full, wr, clr, busy}
  localparam logic [7:0] E_IDLE  = 8'b1000_0000;
  localparam logic [7:0] E_FIRST = 8'b0100_0001;
  localparam logic [7:0] E_DATA  = 8'b0010_0100;
  localparam logic [7:0] E_AFTER = 8'b0001_0101;
  localparam logic [7:0] E_FULL  = 8'b0000_1001;
  localparam logic [7:0] E_PAR   = 8'b0000_0101;
  localparam logic [7:0] E_CHK   = 8'b0000_0011;
  localparam logic [7:0] E_WAIT  = 8'b0000_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pv = 1'b0, full = 1'b0, pd = 1'b0, lpv = 1'b0;
  logic [1:0] addr = '0;
  logic [2:0] empty = '0;
  logic hdr, first, data, after, fh, wr, clr, busy;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pkt_load_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pkt_valid_i(pv), .addr_i(addr),
    .fifo_full_i(full), .fifo_empty_i(empty), .parity_seen_i(pd),
    .pkt_ended_i(lpv), .hdr_detect_o(hdr), .first_load_o(first),
    .data_load_o(data), .after_full_load_o(after), .full_hold_o(fh),
    .wr_en_o(wr), .parity_clr_o(clr), .busy_o(busy)
  );

  task automatic check(input logic [7:0] exp, input string req);
    logic [7:0] act;
    act = {hdr, first, data, after, fh, wr, clr, busy};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] a, input logic f,
                      input logic [2:0] e, input logic p, input logic l);
    @(negedge clk);
    pv = v; addr = a; full = f; empty = e; pd = p; lpv = l;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; pv = 0; full = 0; pd = 0; lpv = 0;
    @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check(E_IDLE, "R1 reset state");
    step(0, 0, 0, 3'b111, 0, 0); check(E_IDLE, "R2 no valid stays idle");

    // sweep idle decision over address and empty patterns
    for (int a = 0; a < 4; a++) begin
      for (int e = 0; e < 8; e++) begin
        logic [7:0] exp;
        do_reset();
        step(1, 2'(a), 0, 3'(e), 0, 0);
        if (a == 3) exp = E_IDLE;
        else        exp = ((e >> a) & 1) != 0 ? E_FIRST : E_WAIT;
        check(exp, a == 3 ? "R2 invalid address" : "R2/R3 idle decision");
        if (exp == E_WAIT) begin
          step(1, 2'd3, 0, ~(3'b001 << a), 0, 0);
          check(E_WAIT, "R3 waits on captured target");
          step(0, 2'd3, 1, 3'b001 << a, 0, 0);
          check(E_FIRST, "R3 target drained");
        end
        if (exp != E_IDLE) begin
          step(0, 2'd3, 1, 3'b000, 1, 1);
          check(E_DATA, "R4 unconditional to data");
        end
      end
    end

    // long path through stall, after-full and parity check
    do_reset();
    step(1, 0, 0, 3'b111, 0, 0); check(E_FIRST, "R2 accept");
    step(1, 0, 0, 3'b000, 0, 0); check(E_DATA, "R4");
    step(1, 0, 0, 3'b000, 0, 0); check(E_DATA, "R5 stays while valid");
    step(0, 0, 1, 3'b000, 0, 0); check(E_FULL, "R5 full wins over end");
    step(0, 0, 1, 3'b000, 0, 0); check(E_FULL, "R8 holds while full");
    step(0, 0, 0, 3'b000, 0, 0); check(E_AFTER, "R8 full drops");
    step(1, 0, 0, 3'b000, 0, 0); check(E_DATA, "R9 back to data");
    step(0, 0, 0, 3'b000, 0, 0); check(E_PAR, "R5 valid low to parity");
    step(0, 0, 1, 3'b000, 0, 0); check(E_CHK, "R6 parity to check");
    step(0, 0, 1, 3'b000, 0, 0); check(E_FULL, "R7 full after check");
    step(0, 0, 0, 3'b000, 0, 0); check(E_AFTER, "R8");
    step(0, 0, 0, 3'b000, 0, 1); check(E_PAR, "R9 ended to parity");
    step(0, 0, 0, 3'b000, 1, 1); check(E_CHK, "R6 unconditional");
    step(0, 0, 0, 3'b000, 0, 0); check(E_IDLE, "R7 check to idle");

    // after-full with parity already seen
    step(1, 2, 0, 3'b100, 0, 0); check(E_FIRST, "R2 port 2");
    step(1, 2, 0, 3'b000, 0, 0); check(E_DATA, "R4");
    step(1, 2, 1, 3'b000, 0, 0); check(E_FULL, "R5 full");
    step(1, 2, 0, 3'b000, 0, 0); check(E_AFTER, "R8");
    step(1, 2, 0, 3'b000, 1, 1); check(E_IDLE, "R9 parity seen wins");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule